// File: doc/BRIEF.md
# Per-Line Trigger Interrupt Controller

The block takes up to 32 raw interrupt inputs and drives one output line per input, strictly one to one: there is no merging, priority logic or vector number. Every line has two configuration bits. One picks edge or level detection and the other picks the active sense. Together they give four trigger types: rising edge, falling edge, active-high level and active-low level.

Software reaches four 32-bit registers inside a 0x20-byte window through a single-cycle valid/write strobe bus. The enable register gates each output. The mode and polarity registers set up detection. The status register shows what each line has detected, before masking. For edge lines, status holds a latched pending flag that software clears by writing 1. For level lines, status simply follows the input. After software changes a line's mode or polarity, it clears that line's status bit to drop any false event that the change produced. Raw inputs may be asynchronous; each one passes through a two-flop synchronizer.

Top module: `icu_trig_ctrl`

## Requirements
- R1: Each output irq_out[i] depends only on input irq_in[i] and on bit i of the registers; activity on any other line never moves it.
- R2: Bit i of the mode register (word offset 0x04) selects edge detection for line i when 1 and level detection when 0.
- R3: Bit i of the polarity register (offset 0x08) selects a rising edge or active-high level when 1, and a falling edge or active-low level when 0.
- R4: In edge mode, a detected edge sets the line's pending flag, which stays set after the input returns to idle. Status reads at offset 0x0C return the flags before masking.
- R5: Writing status with bit i = 1 clears the pending flag of edge line i; a 0 in bit i leaves it unchanged.
- R6: Bit i of the enable register (offset 0x00) passes line i to irq_out[i] when 1; when 0 the output stays low while status still reports the line.
- R7: Reset is synchronous and active low. It leaves enable, mode and polarity at zero (all lines masked, level, active-low) and all outputs low. With inputs held high, status reads zero.
- R8: In level mode the status bit equals the polarity-adjusted synchronized input, and writes to status have no effect on it.
- R9: If an edge is detected in the same cycle as a status write that clears the same line, the pending flag ends up set.
- R10: An input change reaches a level-mode output two clock edges after it is sampled and an edge-mode output three edges after; after one edge the output has not yet moved.
- R11: Reads of word offsets 0x10 to 0x1C return zero, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Bus access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset within the 0x20 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| irq_in | input | 32 | Raw interrupt inputs, may be asynchronous |
| irq_out | output | 32 | Per-line interrupt outputs |

## Verification
The two functions that can land in one cycle are the edge detector setting a pending flag and a software write-1 clearing that same flag. The bench provokes the collision by changing an input and then starting the clear write exactly two clock edges later. At that point the synchronized edge is present during the write's capture edge. The status read that follows must still show the bit set. A control case then checks that a clear without a coinciding edge does empty the flag, so a design that ignores clears cannot pass the collision check by accident.

// File: rtl/icu_pkg.sv
// Shared definitions for the per-line trigger interrupt controller.
// Assumes a word-addressed register layout with 4-byte spacing.
package icu_pkg;
    localparam int unsigned WORD_LSB = 2;

    typedef enum logic [2:0] {
        W_ENABLE   = 3'd0,
        W_MODE     = 3'd1,
        W_POLARITY = 3'd2,
        W_STATUS   = 3'd3
    } icu_word_e;
endpackage

// File: rtl/icu_sync.sv
// Two-flop synchronizer for a vector of independent asynchronous inputs.
// Assumes each bit is a separate, slowly changing level; there is no
// relation between bits. The reset value is chosen by the caller so that
// lines start from their idle level.
module icu_sync #(
    parameter int unsigned WIDTH   = 32,
    parameter bit          RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Metastability stage followed by the settled stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= {WIDTH{RST_VAL}};
            stage2_q <= {WIDTH{RST_VAL}};
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stage2_q == $past(stage1_q))); // R10
endmodule

// File: rtl/icu_line.sv
// Detection and pending state for a single interrupt line.
// Assumes sync_i is already synchronized to clk. In edge mode a polarity
// adjusted rising transition sets a sticky pending flag, and a clear
// request drops it unless an edge lands in the same cycle. In level mode
// status is the adjusted input itself and the flag is held at zero.
module icu_line (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic mode_i,
    input  logic pol_i,
    input  logic clr_i,
    input  logic en_i,
    output logic status_o,
    output logic irq_o
);
    logic prev_q;
    logic pend_q;
    logic act_now;
    logic act_prev;
    logic set_evt;

    // Remember the synchronized input from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_i;
    end

    // Fold polarity in so that "active" always means 1.
    always_comb begin
        act_now  = pol_i ? sync_i : ~sync_i;
        act_prev = pol_i ? prev_q : ~prev_q;
        set_evt  = mode_i & act_now & ~act_prev;
    end

    // Sticky pending flag for edge mode; a set outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (!mode_i) pend_q <= 1'b0;
        else              pend_q <= set_evt | (pend_q & ~clr_i);
    end

    // Status view and masked output.
    always_comb begin
        status_o = mode_i ? pend_q : act_now;
        irq_o    = status_o & en_i;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && set_evt && clr_i) |=> pend_q); // R9
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && clr_i && !set_evt) |=> !pend_q); // R5
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && pend_q && !clr_i) |=> pend_q); // R4
endmodule

// File: rtl/icu_regs.sv
// Register file and bus decode for the interrupt controller.
// Assumes a single-cycle strobe bus: a write is taken on the edge where
// bus_valid and bus_write are both high; read data is combinational and
// only driven while a read strobe is present. Status writes are not stored,
// they leave as a one-cycle clear request vector.
module icu_regs
    import icu_pkg::*;
#(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [N_LINES-1:0] status_i,
    output logic [N_LINES-1:0] en_o,
    output logic [N_LINES-1:0] mode_o,
    output logic [N_LINES-1:0] pol_o,
    output logic [N_LINES-1:0] clr_o
);
    localparam int unsigned WORD_W = ADDR_W - WORD_LSB;

    logic [WORD_W-1:0]  word;
    logic               wr_go;
    logic               rd_go;
    logic [N_LINES-1:0] en_q;
    logic [N_LINES-1:0] mode_q;
    logic [N_LINES-1:0] pol_q;
    logic [N_LINES-1:0] rd_line;

    assign word  = bus_addr[ADDR_W-1:WORD_LSB];
    assign wr_go = bus_valid & bus_write;
    assign rd_go = bus_valid & ~bus_write;

    // Configuration registers, written by word offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mode_q <= '0;
            pol_q  <= '0;
        end else if (wr_go) begin
            case (word)
                WORD_W'(W_ENABLE):   en_q   <= bus_wdata[N_LINES-1:0];
                WORD_W'(W_MODE):     mode_q <= bus_wdata[N_LINES-1:0];
                WORD_W'(W_POLARITY): pol_q  <= bus_wdata[N_LINES-1:0];
                default: ;
            endcase
        end
    end

    // Write-one-to-clear request towards the line cells.
    always_comb begin
        clr_o = '0;
        if (wr_go && word == WORD_W'(W_STATUS)) clr_o = bus_wdata[N_LINES-1:0];
    end

    // Read mux; unused words in the window return zero.
    always_comb begin
        rd_line = '0;
        case (word)
            WORD_W'(W_ENABLE):   rd_line = en_q;
            WORD_W'(W_MODE):     rd_line = mode_q;
            WORD_W'(W_POLARITY): rd_line = pol_q;
            WORD_W'(W_STATUS):   rd_line = status_i;
            default:             rd_line = '0;
        endcase
        bus_rdata = '0;
        if (rd_go) bus_rdata[N_LINES-1:0] = rd_line;
    end

    assign en_o   = en_q;
    assign mode_o = mode_q;
    assign pol_o  = pol_q;

    AST_CFG_STABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_go || word > WORD_W'(W_STATUS)) |=>
            ($stable(en_q) && $stable(mode_q) && $stable(pol_q))); // R11
endmodule

// File: rtl/icu_trig_ctrl.sv
// Top of the per-line trigger interrupt controller.
// Assumes N_LINES <= DATA_W and a 0x20-byte window (ADDR_W = 5). Each raw
// input is synchronized, detected by its own line cell and driven straight
// to its own output; lines never interact.
module icu_trig_ctrl #(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [N_LINES-1:0] irq_in,
    output logic [N_LINES-1:0] irq_out
);
    logic [N_LINES-1:0] sync_v;
    logic [N_LINES-1:0] en_v;
    logic [N_LINES-1:0] mode_v;
    logic [N_LINES-1:0] pol_v;
    logic [N_LINES-1:0] clr_v;
    logic [N_LINES-1:0] status_v;

    icu_sync #(.WIDTH(N_LINES), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_in),
        .sync_o  (sync_v)
    );

    icu_regs #(.N_LINES(N_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .status_i  (status_v),
        .en_o      (en_v),
        .mode_o    (mode_v),
        .pol_o     (pol_v),
        .clr_o     (clr_v)
    );

    // One independent detector per line.
    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
        icu_line u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_i   (sync_v[gi]),
            .mode_i   (mode_v[gi]),
            .pol_i    (pol_v[gi]),
            .clr_i    (clr_v[gi]),
            .en_i     (en_v[gi]),
            .status_o (status_v[gi]),
            .irq_o    (irq_out[gi])
        );
    end

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~en_v) == '0); // R6
    AST_OUT_IMPLIES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~status_v) == '0); // R1
endmodule

// File: tb/icu_trig_ctrl_tb.sv
module icu_trig_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_EN = 5'h00, A_MODE = 5'h04, A_POL = 5'h08, A_STAT = 5'h0C;

    // Vector: {mode, polarity, input before, input after, expected out}
    localparam logic [4:0] VEC_TAB [0:7] = '{
        5'b11011, 5'b11100, 5'b10101, 5'b10010,
        5'b01011, 5'b01100, 5'b00101, 5'b00010
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '1;
    logic [31:0] irq_out;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    icu_trig_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; the write is taken on the next rising edge.
    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        logic [31:0] en_keep;
        wait_cyc(5);
        rst_n = 1'b1;
        // R7: reset state with inputs high
        bus_rd(A_EN, rd);   chk("R7 enable", rd, 32'h0);
        bus_rd(A_MODE, rd); chk("R7 mode", rd, 32'h0);
        bus_rd(A_POL, rd);  chk("R7 polarity", rd, 32'h0);
        bus_rd(A_STAT, rd); chk("R7 status", rd, 32'h0);
        chk("R7 outputs", irq_out, 32'h0);

        // R2 R3 table walk on line 0
        bus_wr(A_EN, 32'h1);
        for (int i = 0; i < 8; i++) begin
            logic [4:0] v;
            v = VEC_TAB[i];
            bus_wr(A_MODE, {31'b0, v[4]});
            bus_wr(A_POL, {31'b0, v[3]});
            irq_in[0] = v[2];
            wait_cyc(4);
            bus_wr(A_STAT, 32'h1);
            irq_in[0] = v[1];
            wait_cyc(4);
            chk($sformatf("R2 R3 vector %0d", i), {31'b0, irq_out[0]}, {31'b0, v[0]});
        end

        // R1: only line 5 fires among 32 edge lines
        bus_wr(A_EN, 32'hFFFF_FFFF);
        bus_wr(A_MODE, 32'hFFFF_FFFF);
        bus_wr(A_POL, 32'hFFFF_FFFF);
        irq_in = '0;
        wait_cyc(4);
        bus_wr(A_STAT, 32'hFFFF_FFFF);
        wait_cyc(1);
        chk("R1 quiet before", irq_out, 32'h0);
        irq_in[5] = 1'b1;
        wait_cyc(4);
        chk("R1 one to one", irq_out, 32'h0000_0020);
        // R4: sticky after input returns idle
        irq_in[5] = 1'b0;
        wait_cyc(4);
        chk("R4 sticky", irq_out, 32'h0000_0020);
        // R6: mask keeps output low, status still set
        bus_wr(A_EN, 32'hFFFF_FFDF);
        chk("R6 masked out", irq_out, 32'h0);
        bus_rd(A_STAT, rd); chk("R4 R6 status unmasked", rd, 32'h0000_0020);
        bus_wr(A_EN, 32'hFFFF_FFFF);
        chk("R6 unmasked out", irq_out, 32'h0000_0020);
        // R5: writing 0 keeps, writing 1 clears
        bus_wr(A_STAT, 32'hFFFF_FFDF);
        bus_rd(A_STAT, rd); chk("R5 zero write", rd, 32'h0000_0020);
        bus_wr(A_STAT, 32'h0000_0020);
        bus_rd(A_STAT, rd); chk("R5 one write", rd, 32'h0);

        // R9: edge and clear in the same cycle on line 3
        irq_in[3] = 1'b1;
        wait_cyc(2);
        bus_wr(A_STAT, 32'h0000_0008);
        bus_rd(A_STAT, rd); chk("R9 set wins", rd, 32'h0000_0008);
        bus_wr(A_STAT, 32'h0000_0008);
        bus_rd(A_STAT, rd); chk("R9 control clear", rd, 32'h0);

        // R8: level line ignores status writes
        bus_wr(A_MODE, 32'hFFFF_FFDF);
        irq_in[5] = 1'b1;
        wait_cyc(4);
        bus_wr(A_STAT, 32'h0000_0020);
        bus_rd(A_STAT, rd); chk("R8 level ignores clear", rd, 32'h0000_0020);
        irq_in[5] = 1'b0;
        wait_cyc(3);
        bus_rd(A_STAT, rd); chk("R8 level follows", rd, 32'h0);

        // R10: level path latency on line 7 (mode 0, polarity 1)
        bus_wr(A_MODE, 32'hFFFF_FF5F);
        wait_cyc(3);
        irq_in[7] = 1'b1;
        wait_cyc(1);
        chk("R10 not after one edge", {31'b0, irq_out[7]}, 32'h0);
        wait_cyc(1);
        chk("R10 level after two edges", {31'b0, irq_out[7]}, 32'h1);
        // R10: edge path latency on line 9
        irq_in[9] = 1'b1;
        wait_cyc(2);
        chk("R10 edge not after two", {31'b0, irq_out[9]}, 32'h0);
        wait_cyc(1);
        chk("R10 edge after three", {31'b0, irq_out[9]}, 32'h1);

        // R11: unused offsets
        bus_rd(A_EN, en_keep);
        bus_wr(5'h10, 32'h0);
        bus_wr(5'h14, 32'h0);
        bus_wr(5'h1C, 32'h0);
        bus_rd(A_EN, rd);   chk("R11 enable kept", rd, en_keep);
        bus_rd(A_MODE, rd); chk("R11 mode kept", rd, 32'hFFFF_FF5F);
        bus_rd(5'h18, rd);  chk("R11 read zero", rd, 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule